// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the 32-bit datapath of a processor that spends several clock cycles on each instruction. It holds the program counter, the instruction register, a memory data register, two operand registers, a result register and a 32-entry register file. A single ALU and a set of selection muxes complete it. One memory port serves both instruction fetch and data access, so the block presents a single address and a single write-data bus, and it accepts one read-data bus.

All steering comes from control inputs that an external sequencer drives in each cycle. The block returns the opcode and function fields of the held instruction and a live ALU zero flag, which the sequencer uses to choose its next step.

The operand registers, the memory data register and the result register carry values from one cycle to the next. As a result, one ALU can compute the incremented PC during fetch and the branch target during decode, and still compare the operands in a later cycle.

Top module: `mcyc_datapath`

## Requirements
- R1: After reset, the PC holds RESET_PC (default 0). The instruction register, operand registers, memory data register and result register are all 0, and every register file entry reads 0.
- R2: `iord_sel`=0 puts the PC on `mem_addr`. `iord_sel`=1 puts the result register on it.
- R3: The instruction register captures `mem_rdata` at a clock edge only when `ir_load`=1 and otherwise holds its value. `opcode` is instruction bits [31:26] and `funct` is bits [5:0].
- R4: At every edge, operand register A loads the register file entry indexed by instruction bits [25:21] and operand register B loads the entry indexed by bits [20:16]. `mem_wdata` always shows B.
- R5: `alu_a_sel` 0 selects the PC and 1 selects A. `alu_b_sel` has four codes: 0 selects B, 1 selects the constant 4, 2 selects instruction bits [15:0] sign-extended, and 3 selects that sign-extended value shifted left by two.
- R6: `alu_fn` codes: 0 add, 1 subtract, 2 AND, 3 OR, and 4 signed set-less-than, which gives 1 or 0. Codes 5 to 7 give 0. `alu_zero` is 1 in the same cycle when the live ALU result is 0.
- R7: When `rf_we`=1, the register file is written at the edge. `rf_dst_sel` 0 takes the index from bits [20:16] and 1 takes it from bits [15:11]. `rf_wdata_sel` 0 writes the result register and 1 writes the memory data register.
- R8: Register file entry 0 always reads 0. Writes to it have no effect.
- R9: The PC is updated at an edge when `pc_load`=1, or when `pc_load_cond`=1 and `alu_zero`=1. Otherwise it holds its value.
- R10: `pc_src` codes: 0 loads the live ALU result, 1 loads the result register, and 2 loads the jump target. The jump target is PC bits [31:28], then instruction bits [25:0], then two zero bits.
- R11: The memory data register captures `mem_rdata` at every edge. The result register captures the live ALU result at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iord_sel | input | 1 | Memory address select: PC or result register |
| ir_load | input | 1 | Instruction register load enable |
| pc_load | input | 1 | Unconditional PC write |
| pc_load_cond | input | 1 | PC write when the ALU zero flag is set |
| pc_src | input | 2 | PC source select |
| alu_a_sel | input | 1 | ALU first operand select |
| alu_b_sel | input | 2 | ALU second operand select |
| alu_fn | input | 3 | ALU function code |
| rf_we | input | 1 | Register file write enable |
| rf_dst_sel | input | 1 | Write index select: bits [20:16] or [15:11] |
| rf_wdata_sel | input | 1 | Write data select: result register or memory data register |
| mem_rdata | input | 32 | Read data from the shared memory |
| mem_addr | output | 32 | Address to the shared memory |
| mem_wdata | output | 32 | Write data to memory (operand register B) |
| opcode | output | 6 | Instruction bits [31:26] |
| funct | output | 6 | Instruction bits [5:0] |
| alu_zero | output | 1 | Live ALU result equals zero |

## Verification
Some properties are checked on every cycle by assertions:
- The instruction register captures and holds as its enable says.
- The PC stays still whenever neither write condition holds.
- A jump keeps the upper four PC bits and clears the lower two.
- A PC load from source 0 takes the previous live ALU result.
- Entry 0 always comes back as zero.
- The address bus shows the previous ALU result when the result register is selected.

Other behaviour can only be shown by the bench scenarios, which compare against a reference model of the register file and the PC:
- ALU arithmetic and the signed compare.
- Sign extension of negative offsets.
- Write-back through both destination fields and both data sources.
- Taken and not-taken conditional branches.
- The reset values.

// File: rtl/mcyc_dp_pkg.sv
package mcyc_dp_pkg;
   // ALU function codes
   localparam logic [2:0] ALU_ADD = 3'd0;
   localparam logic [2:0] ALU_SUB = 3'd1;
   localparam logic [2:0] ALU_AND = 3'd2;
   localparam logic [2:0] ALU_OR  = 3'd3;
   localparam logic [2:0] ALU_SLT = 3'd4;

   // operand select codes
   localparam logic       ASEL_PC   = 1'b0;
   localparam logic       ASEL_REG  = 1'b1;
   localparam logic [1:0] BSEL_REG  = 2'd0;
   localparam logic [1:0] BSEL_FOUR = 2'd1;
   localparam logic [1:0] BSEL_IMM  = 2'd2;
   localparam logic [1:0] BSEL_IMM4 = 2'd3;

   // PC source codes
   localparam logic [1:0] PCSRC_LIVE = 2'd0;
   localparam logic [1:0] PCSRC_HELD = 2'd1;
   localparam logic [1:0] PCSRC_JUMP = 2'd2;

   // address, destination and write-back selects
   localparam logic ADDR_PC  = 1'b0;
   localparam logic ADDR_OUT = 1'b1;
   localparam logic DST_RT   = 1'b0;
   localparam logic DST_RD   = 1'b1;
   localparam logic WB_OUT   = 1'b0;
   localparam logic WB_MDR   = 1'b1;

   // instruction field positions (fixed 32-bit encoding)
   localparam int INSTR_W  = 32;
   localparam int F_OPC_LO = 26;
   localparam int F_RS_LO  = 21;
   localparam int F_RT_LO  = 16;
   localparam int F_RD_LO  = 11;
   localparam int F_IMM_W  = 16;
   localparam int F_JMP_W  = 26;
   localparam int F_FN_W   = 6;
   localparam int F_IDX_W  = 5;
endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 32,
   parameter int IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr_a,
   input  logic [IDX_W-1:0]  raddr_b,
   output logic [DATA_W-1:0] rdata_a,
   output logic [DATA_W-1:0] rdata_b
);
   logic [DATA_W-1:0] regs [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
      if (i == 0) begin : g_zero
         // entry 0 is a constant; writes aimed at it fall away
         assign regs[i] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && (waddr == IDX_W'(i)))
               q <= wdata;
         end
         assign regs[i] = q;
      end
   end

   assign rdata_a = regs[raddr_a];
   assign rdata_b = regs[raddr_b];
endmodule

// File: rtl/mcyc_alu.sv
module mcyc_alu
   import mcyc_dp_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [2:0]        fn,
   output logic [DATA_W-1:0] result,
   output logic              zero
);
   logic lt;

   if (SLT_SIGNED) begin : g_slt_s
      assign lt = ($signed(a) < $signed(b));
   end else begin : g_slt_u
      assign lt = (a < b);
   end

   always_comb begin
      case (fn)
         ALU_ADD: result = a + b;
         ALU_SUB: result = a - b;
         ALU_AND: result = a & b;
         ALU_OR:  result = a | b;
         ALU_SLT: result = {{(DATA_W-1){1'b0}}, lt};
         default: result = '0;
      endcase
   end

   assign zero = (result == '0);
endmodule

// File: rtl/mcyc_opsel.sv
module mcyc_opsel
   import mcyc_dp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [DATA_W-1:0] pc,
   input  logic [DATA_W-1:0] a_reg,
   input  logic [DATA_W-1:0] b_reg,
   input  logic [IMM_W-1:0]  imm,
   input  logic              a_sel,
   input  logic [1:0]        b_sel,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_sx;
   logic [DATA_W-1:0] imm_sx4;

   assign imm_sx  = {{EXT_W{imm[IMM_W-1]}}, imm};
   assign imm_sx4 = {imm_sx[DATA_W-3:0], 2'b00};

   assign opnd_a = (a_sel == ASEL_REG) ? a_reg : pc;

   always_comb begin
      case (b_sel)
         BSEL_REG:  opnd_b = b_reg;
         BSEL_FOUR: opnd_b = DATA_W'(4);
         BSEL_IMM:  opnd_b = imm_sx;
         default:   opnd_b = imm_sx4;
      endcase
   end
endmodule

// File: rtl/mcyc_datapath.sv
module mcyc_datapath
   import mcyc_dp_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                NUM_REGS   = 32,
   parameter logic [DATA_W-1:0] RESET_PC   = '0,
   parameter bit                SLT_SIGNED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iord_sel,
   input  logic              ir_load,
   input  logic              pc_load,
   input  logic              pc_load_cond,
   input  logic [1:0]        pc_src,
   input  logic              alu_a_sel,
   input  logic [1:0]        alu_b_sel,
   input  logic [2:0]        alu_fn,
   input  logic              rf_we,
   input  logic              rf_dst_sel,
   input  logic              rf_wdata_sel,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [5:0]        opcode,
   output logic [5:0]        funct,
   output logic              alu_zero
);
   localparam int IDX_W = $clog2(NUM_REGS);

   // elaboration-time parameter checks
   if (DATA_W != INSTR_W) begin : g_bad_width
      $error("mcyc_datapath: DATA_W must equal the 32-bit instruction width");
   end
   if ((NUM_REGS < 2) || (NUM_REGS > (1 << F_IDX_W)) ||
       ((1 << IDX_W) != NUM_REGS)) begin : g_bad_regs
      $error("mcyc_datapath: NUM_REGS must be a power of two from 2 to 32");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_rpc
      $error("mcyc_datapath: RESET_PC must be word aligned");
   end

   // architectural and inter-cycle registers
   logic [DATA_W-1:0] pc_q;
   logic [DATA_W-1:0] ir_q;
   logic [DATA_W-1:0] mdr_q;
   logic [DATA_W-1:0] a_q;
   logic [DATA_W-1:0] b_q;
   logic [DATA_W-1:0] aluout_q;

   logic [DATA_W-1:0] rd_a;
   logic [DATA_W-1:0] rd_b;
   logic [DATA_W-1:0] opnd_a;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] alu_res;
   logic [DATA_W-1:0] wb_data;
   logic [DATA_W-1:0] jump_tgt;
   logic [DATA_W-1:0] pc_nxt;
   logic [IDX_W-1:0]  ra_idx;
   logic [IDX_W-1:0]  rb_idx;
   logic [IDX_W-1:0]  wr_idx;
   logic              pc_en;

   // instruction field decode
   assign opcode = ir_q[F_OPC_LO +: 6];
   assign funct  = ir_q[0 +: F_FN_W];
   assign ra_idx = ir_q[F_RS_LO +: IDX_W];
   assign rb_idx = ir_q[F_RT_LO +: IDX_W];
   assign wr_idx = (rf_dst_sel == DST_RD) ? ir_q[F_RD_LO +: IDX_W]
                                          : ir_q[F_RT_LO +: IDX_W];
   assign wb_data = (rf_wdata_sel == WB_MDR) ? mdr_q : aluout_q;

   mcyc_regfile #(
      .DATA_W   (DATA_W),
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (wr_idx),
      .wdata   (wb_data),
      .raddr_a (ra_idx),
      .raddr_b (rb_idx),
      .rdata_a (rd_a),
      .rdata_b (rd_b)
   );

   mcyc_opsel #(
      .DATA_W (DATA_W),
      .IMM_W  (F_IMM_W)
   ) u_opsel (
      .pc     (pc_q),
      .a_reg  (a_q),
      .b_reg  (b_q),
      .imm    (ir_q[0 +: F_IMM_W]),
      .a_sel  (alu_a_sel),
      .b_sel  (alu_b_sel),
      .opnd_a (opnd_a),
      .opnd_b (opnd_b)
   );

   mcyc_alu #(
      .DATA_W     (DATA_W),
      .SLT_SIGNED (SLT_SIGNED)
   ) u_alu (
      .a      (opnd_a),
      .b      (opnd_b),
      .fn     (alu_fn),
      .result (alu_res),
      .zero   (alu_zero)
   );

   // next-PC selection
   assign jump_tgt = {pc_q[DATA_W-1 -: 4], ir_q[0 +: F_JMP_W], 2'b00};

   always_comb begin
      case (pc_src)
         PCSRC_HELD: pc_nxt = aluout_q;
         PCSRC_JUMP: pc_nxt = jump_tgt;
         default:    pc_nxt = alu_res;
      endcase
   end

   assign pc_en = pc_load | (pc_load_cond & alu_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_q <= RESET_PC;
      else if (pc_en)
         pc_q <= pc_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ir_q <= '0;
      else if (ir_load)
         ir_q <= mem_rdata;
   end

   // registers that reload on every edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdr_q    <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
      end else begin
         mdr_q    <= mem_rdata;
         a_q      <= rd_a;
         b_q      <= rd_b;
         aluout_q <= alu_res;
      end
   end

   assign mem_addr  = (iord_sel == ADDR_OUT) ? aluout_q : pc_q;
   assign mem_wdata = b_q;
endmodule

// File: rtl/mcyc_datapath_chk.sv
module mcyc_datapath_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iord_sel,
   input logic              ir_load,
   input logic              pc_load,
   input logic              pc_load_cond,
   input logic [1:0]        pc_src,
   input logic [DATA_W-1:0] mem_rdata,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [5:0]        opcode,
   input logic [5:0]        funct,
   input logic              alu_zero,
   input logic [DATA_W-1:0] pc,
   input logic [DATA_W-1:0] alu_res
);
   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         past_ok <= 1'b0;
      else
         past_ok <= 1'b1;
   end

   AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      ir_load |=> (opcode == $past(mem_rdata[31:26])) && (funct == $past(mem_rdata[5:0]))); // R3

   AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_load |=> $stable(opcode) && $stable(funct)); // R3

   AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_load && !(pc_load_cond && alu_zero)) |=> $stable(pc)); // R9

   AST_PC_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && (pc_src == 2'd2)) |=> (pc[31:28] == $past(pc[31:28])) && (pc[1:0] == 2'b00)); // R10

   AST_PC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && (pc_src == 2'd0)) |=> (pc == $past(alu_res))); // R10

   AST_ZERO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (ir_load && (mem_rdata[20:16] == 5'd0)) |=> ##1 (mem_wdata == '0)); // R8

   AST_RESULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && iord_sel) |-> (mem_addr == $past(alu_res))); // R11
endmodule

bind mcyc_datapath mcyc_datapath_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .iord_sel     (iord_sel),
   .ir_load      (ir_load),
   .pc_load      (pc_load),
   .pc_load_cond (pc_load_cond),
   .pc_src       (pc_src),
   .mem_rdata    (mem_rdata),
   .mem_addr     (mem_addr),
   .mem_wdata    (mem_wdata),
   .opcode       (opcode),
   .funct        (funct),
   .alu_zero     (alu_zero),
   .pc           (pc_q),
   .alu_res      (alu_res)
);

// File: tb/mcyc_datapath_tb.sv
module mcyc_datapath_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        iord_sel, ir_load, pc_load, pc_load_cond;
   logic [1:0]  pc_src, alu_b_sel;
   logic        alu_a_sel, rf_we, rf_dst_sel, rf_wdata_sel;
   logic [2:0]  alu_fn;
   logic [31:0] mem_rdata, mem_addr, mem_wdata;
   logic [5:0]  opcode, funct;
   logic        alu_zero;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [31:0] rf_m [32];
   logic [31:0] pc_m;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcyc_datapath u_dut (
      .clk(clk), .rst_n(rst_n), .iord_sel(iord_sel), .ir_load(ir_load),
      .pc_load(pc_load), .pc_load_cond(pc_load_cond), .pc_src(pc_src),
      .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .alu_fn(alu_fn),
      .rf_we(rf_we), .rf_dst_sel(rf_dst_sel), .rf_wdata_sel(rf_wdata_sel),
      .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .opcode(opcode), .funct(funct), .alu_zero(alu_zero)
   );

   function automatic logic [31:0] alu_m(logic [2:0] fn, logic [31:0] a, logic [31:0] b);
      case (fn)
         3'd0: return a + b;
         3'd1: return a - b;
         3'd2: return a & b;
         3'd3: return a | b;
         3'd4: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic [31:0] sx(logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic logic [31:0] mk_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      iord_sel = 0; ir_load = 0; pc_load = 0; pc_load_cond = 0; pc_src = 0;
      alu_a_sel = 0; alu_b_sel = 0; alu_fn = 0; rf_we = 0; rf_dst_sel = 0;
      rf_wdata_sel = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load_ir(logic [31:0] w);
      idle(); ir_load = 1; mem_rdata = w; tick(); idle();
   endtask

   // write through the memory data register (R7 data source 1, R11)
   task automatic write_reg(logic [4:0] r, logic [31:0] v);
      load_ir(mk_i(6'h23, 5'd0, r, 16'h0));
      mem_rdata = v; tick();
      rf_we = 1; rf_dst_sel = 0; rf_wdata_sel = 1; tick();
      idle();
      if (r != 0) rf_m[r] = v;
   endtask

   task automatic read_reg(logic [4:0] r, output logic [31:0] v);
      load_ir(mk_i(6'h2b, r, r, 16'h0));
      tick();
      v = mem_wdata;
   endtask

   task automatic alu_case(logic [2:0] fn, logic [1:0] bsel, logic [4:0] rs, logic [4:0] rt,
                           logic [15:0] imm, string tag);
      logic [31:0] ob, exp;
      load_ir(mk_i(6'h08, rs, rt, imm));
      tick();
      case (bsel)
         2'd0: ob = rf_m[rt];
         2'd1: ob = 32'd4;
         2'd2: ob = sx(imm);
         default: ob = {sx(imm)[29:0], 2'b00};
      endcase
      exp = alu_m(fn, rf_m[rs], ob);
      alu_a_sel = 1; alu_b_sel = bsel; alu_fn = fn; iord_sel = 1;
      #1;
      chk({tag, " R6 zero"}, {31'd0, alu_zero}, {31'd0, exp == 32'd0});
      tick();
      chk({tag, " R5 R11 R2 result"}, mem_addr, exp);
      idle();
   endtask

   task automatic set_pc(logic [31:0] v);
      write_reg(5'd7, v);
      load_ir(mk_i(6'h08, 5'd7, 5'd0, 16'h0));
      tick();
      alu_a_sel = 1; alu_b_sel = 2; alu_fn = 0; pc_load = 1; pc_src = 0;
      tick(); idle();
      pc_m = v;
      chk("R10 live source", mem_addr, pc_m);
   endtask

   task automatic branch(logic [31:0] va, logic [31:0] vb, logic [15:0] off, string tag);
      logic [31:0] tgt;
      write_reg(5'd5, va);
      write_reg(5'd6, vb);
      load_ir(mk_i(6'h04, 5'd5, 5'd6, off));
      tgt = pc_m + {sx(off)[29:0], 2'b00};
      alu_a_sel = 0; alu_b_sel = 3; alu_fn = 0; tick();
      alu_a_sel = 1; alu_b_sel = 0; alu_fn = 1; pc_load_cond = 1; pc_src = 1;
      #1;
      chk({tag, " R6 compare zero"}, {31'd0, alu_zero}, {31'd0, va == vb});
      tick(); idle();
      if (va == vb) pc_m = tgt;
      chk({tag, " R9 R10 pc"}, mem_addr, pc_m);
   endtask

   initial begin
      logic [31:0] v;
      idle(); mem_rdata = 32'h0;
      for (int i = 0; i < 32; i++) rf_m[i] = 32'h0;
      void'($urandom(32'h5eed_0017));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      #1;
      // R1 reset state
      chk("R1 R2 pc on address", mem_addr, 32'h0);
      chk("R1 opcode", {26'd0, opcode}, 32'd0);
      chk("R1 funct", {26'd0, funct}, 32'd0);
      chk("R1 B register", mem_wdata, 32'h0);
      iord_sel = 1; #1;
      chk("R1 R2 result register", mem_addr, 32'h0);
      idle();
      pc_m = 32'h0;

      // R3 capture and hold
      load_ir(32'h8C00_0025);
      chk("R3 opcode capture", {26'd0, opcode}, 32'h23);
      chk("R3 funct capture", {26'd0, funct}, 32'h25);
      mem_rdata = 32'hFFFF_FFFF; tick();
      chk("R3 opcode hold", {26'd0, opcode}, 32'h23);
      chk("R3 funct hold", {26'd0, funct}, 32'h25);

      // R8 entry zero
      write_reg(5'd0, 32'hDEAD_BEEF);
      read_reg(5'd0, v);
      chk("R8 entry 0 reads zero", v, 32'h0);

      // R4 R7 writes through the memory data register
      write_reg(5'd31, 32'h1234_5678);
      read_reg(5'd31, v);
      chk("R4 R7 read back r31", v, 32'h1234_5678);

      // R7 destination from bits 15:11, data from result register
      write_reg(5'd3, 32'd100);
      load_ir({6'h00, 5'd3, 5'd0, 5'd12, 5'd0, 6'h21});
      chk("R3 funct of r-type", {26'd0, funct}, 32'h21);
      tick();
      alu_a_sel = 1; alu_b_sel = 0; alu_fn = 0; tick();
      rf_we = 1; rf_dst_sel = 1; rf_wdata_sel = 0; tick(); idle();
      rf_m[12] = 32'd100;
      read_reg(5'd12, v);
      chk("R7 rd destination", v, 32'd100);
      read_reg(5'd0, v);
      chk("R7 R8 rt untouched", v, 32'h0);

      // R5 sign extension directed cases
      write_reg(5'd9, 32'd10);
      alu_case(3'd0, 2'd2, 5'd9, 5'd0, 16'h8004, "imm neg");
      alu_case(3'd0, 2'd3, 5'd9, 5'd0, 16'hFFFF, "imm shifted");
      alu_case(3'd0, 2'd1, 5'd9, 5'd0, 16'h0, "const four");
      write_reg(5'd10, 32'hFFFF_FFFE);
      alu_case(3'd4, 2'd0, 5'd10, 5'd9, 16'h0, "slt signed");
      alu_case(3'd1, 2'd0, 5'd9, 5'd9, 16'h0, "sub equal");

      // R9 R10 fetch increment
      for (int k = 0; k < 2; k++) begin
         alu_a_sel = 0; alu_b_sel = 1; alu_fn = 0; pc_load = 1; pc_src = 0;
         tick(); idle();
         pc_m = pc_m + 4;
         chk("R9 R10 pc plus four", mem_addr, pc_m);
      end

      set_pc(32'h0000_4000);
      branch(32'h55, 32'h55, 16'hFFFD, "taken");
      branch(32'h55, 32'h56, 16'h0010, "not taken");

      // R10 jump keeps top PC bits
      set_pc(32'hA000_0100);
      load_ir({6'h02, 26'h123_4567});
      pc_load = 1; pc_src = 2; tick(); idle();
      pc_m = {4'hA, 26'h123_4567, 2'b00};
      chk("R10 jump target", mem_addr, pc_m);

      // constrained random ALU traffic
      for (int n = 0; n < 60; n++) begin
         logic [4:0] rs, rt;
         logic [31:0] va, vb;
         rs = 5'(1 + ($urandom % 31));
         rt = 5'(1 + ($urandom % 31));
         va = $urandom;
         vb = (($urandom % 4) == 0) ? va : $urandom;
         write_reg(rs, va);
         write_reg(rt, vb);
         alu_case(3'($urandom % 8), 2'($urandom % 4), rs, rt, 16'($urandom), "random");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog R1 actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule